// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This block holds the line-control and line-status registers of a serial port's modem interface. Software writes a small control register to drive four active-low handshake outputs (terminal ready, request to send and two general-purpose outputs), and reads a status register. The status register reports the present level of four active-low modem inputs (clear to send, data set ready, ring indicator, carrier detect) and a sticky change flag per input. Each input passes through a multi-flop synchronizer before it is compared with its previous value. A read of the status register clears the change flags. When the host enables the modem interrupt, any set change flag raises an interrupt request.

A loopback bit turns the block into a self-test path. While it is set, all four outputs are held at their inactive (high) level, the external inputs are ignored, and the four output control bits are routed back as the status inputs. Software can therefore create any status change, and the change flags it causes, without touching the external lines. The serial data path is not part of this block.

Top module: `mdm_ctl_status`

## Requirements
- R1: After reset (`rst` high, active high) the control register reads 0x00, the status register reads 0x00, all four outputs are high and `irq` is low.
- R2: A write with `addr`=0 stores `wdata[4:0]` in the control register. A read at `addr`=0 returns those five bits, with bits 7:5 reading 0. Bit 0 is terminal ready, bit 1 is request to send, bit 2 is general output 1, bit 3 is general output 2 and bit 4 is loopback.
- R3: With loopback clear, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are the inverse of control bits 0, 1, 2 and 3. They change by the falling clock edge after the write.
- R4: With loopback set, all four outputs are high, whatever control bits 3:0 hold.
- R5: A read with `addr`=1 returns the line state in bits 7:4: bit 4 is clear to send, bit 5 is data set ready, bit 6 is ring indicator and bit 7 is carrier detect. Each bit is 1 while its active-low pin is low. A pin change is visible two rising edges after it is applied.
- R6: Status bits 0, 1 and 3 become 1 when the clear to send, data set ready or carrier detect state changes in either direction. They stay set until a status read.
- R7: Status bit 2 becomes 1 only when the ring indicator state goes from 1 to 0 (the pin returns high). The opposite transition does not set it.
- R8: A status read returns the change flags as they were before the read, and clears them at the end of that read cycle.
- R9: A change flag whose input changes in the same cycle as a status read stays set after that read.
- R10: In loopback, the status reads clear to send from control bit 1, data set ready from bit 0, ring indicator from bit 2 and carrier detect from bit 3. The external inputs have no effect.
- R11: `irq` is high exactly when `msi_en` is high and at least one change flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (a status read clears change flags) |
| addr | input | 1 | 0 = control register, 1 = status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| msi_en | input | 1 | Modem interrupt enable |
| cts_n | input | 1 | Clear to send, active low |
| dsr_n | input | 1 | Data set ready, active low |
| ri_n | input | 1 | Ring indicator, active low |
| dcd_n | input | 1 | Carrier detect, active low |
| dtr_n | output | 1 | Terminal ready, active low |
| rts_n | output | 1 | Request to send, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| irq | output | 1 | Modem status interrupt request |

## Verification
The hardest case to reach is a status read that falls in the same cycle as a fresh change on a line. A read in that cycle must return the flag as still clear and must leave it set afterwards. The stimulus gets there by counting the synchronizer delay: it moves a pin on a falling edge, waits exactly two rising edges, and issues the status read in the cycle in which the synchronized level first differs from the stored one. A second read then shows the flag that survived. Loopback is also used to create changes on all four lines at once from a single register write, including the ring-indicator trailing edge.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
   localparam int LINES = 4;
   localparam int CTL_W = 5;
   // control register bit positions
   localparam int CTL_DTR  = 0;
   localparam int CTL_RTS  = 1;
   localparam int CTL_OUT1 = 2;
   localparam int CTL_OUT2 = 3;
   localparam int CTL_LOOP = 4;
   // status line positions (status bit = position + LINES, flag = position)
   localparam int LN_CTS = 0;
   localparam int LN_DSR = 1;
   localparam int LN_RI  = 2;
   localparam int LN_DCD = 3;
   // lines whose flag fires only on a 1 -> 0 state transition
   localparam logic [LINES-1:0] TRAIL_MASK = 4'b0100;

   typedef logic [LINES-1:0] line_vec_t;
   typedef logic [CTL_W-1:0] ctl_vec_t;
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
   parameter int          WIDTH   = 4,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mdm_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (rst) chain[0] <= RST_VAL;
      else     chain[0] <= d;
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) chain[k] <= RST_VAL;
         else     chain[k] <= chain[k-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg #(
   parameter int DATA_W = 8,
   parameter int CTL_W  = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [CTL_W-1:0]  q
);
   generate
      if (DATA_W <= CTL_W) begin : g_bad_w
         $error("mdm_ctl_reg: DATA_W must exceed CTL_W");
      end
   endgenerate

   logic unused_wr_hi;
   assign unused_wr_hi = ^wdata[DATA_W-1:CTL_W];

   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (we) q <= wdata[CTL_W-1:0];
   end
endmodule

// File: rtl/mdm_delta.sv
module mdm_delta #(
   parameter int               WIDTH = 4,
   parameter logic [WIDTH-1:0] TRAIL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] cur,
   input  logic             clr,
   output logic [WIDTH-1:0] chg,
   output logic [WIDTH-1:0] flag
);
   logic [WIDTH-1:0] prev;

   for (genvar i = 0; i < WIDTH; i++) begin : g_det
      if (TRAIL[i]) begin : g_trail
         assign chg[i] = prev[i] & ~cur[i];
      end else begin : g_any
         assign chg[i] = prev[i] ^ cur[i];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         prev <= '0;
         flag <= '0;
      end else begin
         prev <= cur;
         flag <= (clr ? '0 : flag) | chg;
      end
   end
endmodule

// File: rtl/mdm_ctl_status.sv
module mdm_ctl_status
   import mdm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic              addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              msi_en,
   input  logic              cts_n,
   input  logic              dsr_n,
   input  logic              ri_n,
   input  logic              dcd_n,
   output logic              dtr_n,
   output logic              rts_n,
   output logic              out1_n,
   output logic              out2_n,
   output logic              irq
);
   localparam int STAT_W = 2 * LINES;

   generate
      if (DATA_W < STAT_W) begin : g_bad_data_w
         $error("mdm_ctl_status: DATA_W too small for status word");
      end
   endgenerate

   ctl_vec_t  ctl_q;
   line_vec_t pin_n, pin_s, ext_st, lb_st, line_st, chg, flag_q;
   logic [LINES-1:0] drv_n;
   logic      loop_on, rd_stat;

   mdm_ctl_reg #(.DATA_W(DATA_W), .CTL_W(CTL_W)) u_ctl (
      .clk(clk), .rst(rst), .we(wr_en & ~addr), .wdata(wdata), .q(ctl_q)
   );

   assign loop_on = ctl_q[CTL_LOOP];

   // outputs: inverse of control bit, held high in loopback
   for (genvar i = 0; i < LINES; i++) begin : g_drv
      assign drv_n[i] = loop_on | ~ctl_q[i];
   end
   assign dtr_n  = drv_n[CTL_DTR];
   assign rts_n  = drv_n[CTL_RTS];
   assign out1_n = drv_n[CTL_OUT1];
   assign out2_n = drv_n[CTL_OUT2];

   assign pin_n[LN_CTS] = cts_n;
   assign pin_n[LN_DSR] = dsr_n;
   assign pin_n[LN_RI]  = ri_n;
   assign pin_n[LN_DCD] = dcd_n;

   mdm_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
      .clk(clk), .rst(rst), .d(pin_n), .q(pin_s)
   );

   assign ext_st = ~pin_s;

   assign lb_st[LN_CTS] = ctl_q[CTL_RTS];
   assign lb_st[LN_DSR] = ctl_q[CTL_DTR];
   assign lb_st[LN_RI]  = ctl_q[CTL_OUT1];
   assign lb_st[LN_DCD] = ctl_q[CTL_OUT2];

   assign line_st = loop_on ? lb_st : ext_st;
   assign rd_stat = rd_en & addr;

   mdm_delta #(.WIDTH(LINES), .TRAIL(TRAIL_MASK)) u_delta (
      .clk(clk), .rst(rst), .cur(line_st), .clr(rd_stat),
      .chg(chg), .flag(flag_q)
   );

   assign irq   = msi_en & (|flag_q);
   assign rdata = addr ? DATA_W'({line_st, flag_q}) : DATA_W'(ctl_q);
endmodule

// File: rtl/mdm_ctl_status_chk.sv
module mdm_ctl_status_chk (
   input logic       clk,
   input logic       rst,
   input logic       rd_stat,
   input logic       msi_en,
   input logic       irq,
   input logic [4:0] ctl_q,
   input logic [3:0] pins_n,
   input logic [3:0] flag_q,
   input logic [3:0] chg
);
   // R4
   loop_outs_idle_chk: assert property (@(posedge clk) disable iff (rst)
      ctl_q[4] |-> (pins_n == 4'hF));

   // R11
   irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      !msi_en |-> !irq);

   // R11
   irq_raised_chk: assert property (@(posedge clk) disable iff (rst)
      (msi_en && (flag_q != 4'h0)) |-> irq);

   // R8
   read_clears_chk: assert property (@(posedge clk) disable iff (rst)
      rd_stat |=> ((flag_q & ~$past(chg)) == 4'h0));

   // R6
   flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      !rd_stat |=> ((flag_q & $past(flag_q)) == $past(flag_q)));

   // R9
   same_cycle_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (rd_stat && (chg != 4'h0)) |=> ((flag_q & $past(chg)) == $past(chg)));
endmodule

bind mdm_ctl_status mdm_ctl_status_chk u_chk (
   .clk(clk), .rst(rst), .rd_stat(rd_stat), .msi_en(msi_en), .irq(irq),
   .ctl_q(ctl_q), .pins_n({out2_n, out1_n, rts_n, dtr_n}),
   .flag_q(flag_q), .chg(chg)
);

// File: tb/sim_mdm_ctl_status.sv
module sim_mdm_ctl_status;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, msi_en = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
   logic dtr_n, rts_n, out1_n, out2_n, irq;

   always #4 clk = ~clk;

   mdm_ctl_status u0 (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .msi_en(msi_en),
      .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
      .dtr_n(dtr_n), .rts_n(rts_n), .out1_n(out1_n), .out2_n(out2_n), .irq(irq)
   );

   typedef struct {
      bit         is_pins;
      logic [7:0] exp;
      string      tag;
   } item_t;

   item_t q[$];
   event  smp;
   int    n_cmp = 0, n_bad = 0;
   bit    done = 1'b0;

   // monitor: pops expected items when the driver signals a sample point
   initial begin
      forever begin
         @(smp);
         if (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = q.pop_front();
            act = it.is_pins ? {3'b000, dtr_n, rts_n, out1_n, out2_n, irq} : rdata;
            n_cmp++;
            if (act !== it.exp) begin
               n_bad++;
               $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctl(input logic [7:0] v);
      wr_en = 1'b1; addr = 1'b0; wdata = v;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input logic a, input logic [7:0] e, input string tag);
      item_t it;
      addr = a; rd_en = 1'b1;
      it.is_pins = 1'b0; it.exp = e; it.tag = tag;
      q.push_back(it);
      #1 -> smp;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   // expected = {dtr_n, rts_n, out1_n, out2_n, irq}
   task automatic pins_chk(input logic [4:0] e, input string tag);
      item_t it;
      it.is_pins = 1'b1; it.exp = {3'b000, e}; it.tag = tag;
      q.push_back(it);
      #1 -> smp;
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      tick(3);
      rst = 1'b0;
      tick(1);
      rd_chk(1'b0, 8'h00, "R1 ctl reset");
      rd_chk(1'b1, 8'h00, "R1 status reset");
      pins_chk(5'b11110, "R1 pins reset");

      wr_ctl(8'h0F);
      rd_chk(1'b0, 8'h0F, "R2 ctl readback");
      pins_chk(5'b00000, "R3 all active");
      wr_ctl(8'h05);
      pins_chk(5'b01010, "R3 dtr out1 active");
      wr_ctl(8'hFF);
      rd_chk(1'b0, 8'h1F, "R2 upper bits zero");
      pins_chk(5'b11110, "R4 loopback idle outs");
      // flags were set one edge after the write; wr_ctl + pins_chk passed it
      rd_chk(1'b1, 8'hFB, "R10 loopback all lines");
      wr_ctl(8'h1B);
      tick(1);
      rd_chk(1'b1, 8'hB4, "R7 loopback ri trailing");
      cts_n = 1'b0;
      tick(4);
      rd_chk(1'b1, 8'hB0, "R10 external ignored");
      cts_n = 1'b1;
      tick(4);
      wr_ctl(8'h00);
      tick(1);
      rd_chk(1'b1, 8'h0B, "R10 exit loopback");

      // same-cycle read and change
      cts_n = 1'b0;
      tick(2);
      rd_chk(1'b1, 8'h10, "R9 read during change");
      rd_chk(1'b1, 8'h11, "R9 flag kept");
      rd_chk(1'b1, 8'h10, "R8 flag cleared");

      dsr_n = 1'b0;
      tick(3);
      pins_chk(5'b11110, "R11 masked irq");
      msi_en = 1'b1;
      pins_chk(5'b11111, "R11 irq raised");
      rd_chk(1'b1, 8'h32, "R6 dsr change");
      pins_chk(5'b11110, "R11 irq after clear");

      ri_n = 1'b0;
      tick(3);
      rd_chk(1'b1, 8'h70, "R7 ri assert no flag");
      ri_n = 1'b1;
      tick(3);
      rd_chk(1'b1, 8'h34, "R7 ri trailing flag");
      dcd_n = 1'b0;
      tick(3);
      rd_chk(1'b1, 8'hB8, "R5 R6 dcd");
      dcd_n = 1'b1; cts_n = 1'b1;
      tick(3);
      rd_chk(1'b1, 8'h29, "R6 two lines release");
      pins_chk(5'b11110, "R11 idle after read");

      wr_ctl(8'h0F);
      rst = 1'b1;
      tick(2);
      rst = 1'b0;
      rd_chk(1'b0, 8'h00, "R1 ctl after reset");
      pins_chk(5'b11110, "R1 pins after reset");

      tick(2);
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL queue: actual %0d expected 0", q.size());
      end
      finish_run();
   end
endmodule